// File: doc/BRIEF.md
# Sign-Sign LMS Equalizer Adaptation Engine

This block trains the coefficients of a receive equalizer: a feed-forward filter with pre-cursor taps, a fixed main cursor and post-cursor taps, one decision-feedback tap, and the four PAM4 slicer levels. For every valid symbol it receives the sign of the slicer error, the decided PAM4 symbol and the signs of the samples held in each feed-forward tap position. For each adapted parameter it forms the product of the error sign and the relevant data sign, and it keeps a running signed sum of these products.

Updates are batched. After a fixed window of valid symbols, each adapted coefficient moves by one LSB in the direction its sum calls for. A zero sum leaves it unchanged. Coefficients saturate at their signed limits. A one-cycle strobe marks every window boundary so that downstream monitors can sample the fresh coefficient set. An enable mask holds chosen feed-forward taps at zero. The main cursor is pinned at unity and the first post-cursor tap is pinned at zero. The filter datapath itself sits outside this block.

Top module: `lms_ss_adapt`

## Requirements
- R1: While reset is active and right after it, every tap output is 0 except tap NUM_PRE, which is 2**(COEF_W-2). The DFE output is 0. The level fields are -LVL_OUT_INIT, -LVL_IN_INIT, +LVL_IN_INIT and +LVL_OUT_INIT. done_o is 0.
- R2: Tap k sits at taps_o[k*COEF_W +: COEF_W]. Index 0 is the earliest pre-cursor and index NUM_PRE is the main cursor. Each symbol's product is +1 when err_neg_i equals x_neg_i[k] and -1 otherwise, where 1 on either input means negative. At a window end, an enabled adapted tap decreases by 1 if its product sum is positive and increases by 1 if the sum is negative. Between window ends the tap does not change.
- R3: A window is 2**WIN_LOG2 cycles with sym_vld_i high. Cycles with sym_vld_i low are not counted and change no sum. done_o is high for exactly one cycle, the cycle after the last symbol of a window, and the updated coefficients are visible in that same cycle. All sums restart from zero for the next window.
- R4: A parameter whose product sum is exactly zero at the window end keeps its value.
- R5: Tap NUM_PRE stays at 2**(COEF_W-2) and tap NUM_PRE+1 stays at 0, whatever the inputs and the mask.
- R6: If tap_en_i[k] is 0 for an adapted tap, that tap reads 0 from the next cycle on and ignores window updates. When the tap is enabled again, it adapts from 0 with a fresh sum.
- R7: Taps and the DFE coefficient saturate at 2**(COEF_W-1)-1 and -2**(COEF_W-1) and never wrap.
- R8: The DFE product is +1 when err_neg_i differs from bit 1 of the previous valid decision (bit 1 set means a positive level), and -1 otherwise. The previous decision is symbol 0 after reset. At a window end, a positive sum raises the DFE coefficient by 1 and a negative sum lowers it by 1. The DFE coefficient changes only at window ends.
- R9: Symbols 0, 1, 2 and 3 mean levels -3, -1, +1 and +3, reported in lvl_o fields 0 to 3. Symbols 0 and 3 update only the outer magnitude, and symbols 1 and 2 update only the inner one. The product is +1 when err_neg_i equals the inverse of bit 1 of the symbol. At a window end, each magnitude moves by 1 in the sign of its sum.
- R10: The levels stay symmetric, with field 0 equal to minus field 3 and field 1 equal to minus field 2. The levels stay ordered, with the inner magnitude at least 1 and at most the outer magnitude minus 1. The outer magnitude is clamped to no more than 2**(LVL_W-1)-1 and no less than the old inner magnitude plus 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_vld_i | input | 1 | Symbol inputs are valid this cycle |
| err_neg_i | input | 1 | Slicer error is negative |
| sym_i | input | 2 | Decided PAM4 symbol, 0..3 = -3,-1,+1,+3 |
| x_neg_i | input | NUM_PRE+NUM_POST+1 | Per-tap sign of the sample in that tap position, 1 = negative |
| tap_en_i | input | NUM_PRE+NUM_POST+1 | Per-tap enable mask |
| taps_o | output | (NUM_PRE+NUM_POST+1)*COEF_W | Packed signed tap coefficients |
| dfe_o | output | COEF_W | Signed DFE coefficient |
| lvl_o | output | 4*LVL_W | Packed signed slicer levels, field i for symbol i |
| done_o | output | 1 | One-cycle window-boundary strobe |

## Verification
Several window patterns are applied. In one, every product has the same sign, so every free tap, the DFE tap and one level move in a known direction. In another, the error sign alternates, so the tap sums cancel exactly and the zero-sum hold shows. A third mixes symbol classes and sample signs, so the inner and outer level sums separate from the tap sums. A fourth is interleaved with invalid cycles, which shows that the window counts only valid symbols. Long runs of the same pattern drive the taps and the DFE coefficient into both saturation limits and push the level magnitudes against their ordering clamps. Mask changes made in the middle of a run separate the masked taps from the free ones.

// File: rtl/lms_ss_pkg.sv
package lms_ss_pkg;

  typedef enum logic [1:0] {
    TAP_ADAPT = 2'd0,
    TAP_UNITY = 2'd1,
    TAP_ZERO  = 2'd2
  } tap_kind_e;

  // main cursor pinned to unity, first post-cursor pinned to zero
  function automatic tap_kind_e kind_of(input int idx, input int main_idx);
    if (idx == main_idx)     return TAP_UNITY;
    if (idx == main_idx + 1) return TAP_ZERO;
    return TAP_ADAPT;
  endfunction

endpackage

// File: rtl/lms_sign_acc.sv
module lms_sign_acc #(
  parameter int unsigned ACC_W = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnt_i,
  input  logic pos_i,
  input  logic flush_i,
  input  logic zero_i,
  output logic inc_o,
  output logic dec_o
);

  localparam logic signed [ACC_W-1:0] ONE = {{(ACC_W-1){1'b0}}, 1'b1};

  logic signed [ACC_W-1:0] acc_q, sum;

  // sum includes the current symbol so a flush sees the whole window
  always_comb begin
    sum = acc_q;
    if (zero_i)     sum = '0;
    else if (cnt_i) sum = pos_i ? acc_q + ONE : acc_q - ONE;
  end

  assign inc_o = !sum[ACC_W-1] && (sum != '0);
  assign dec_o = sum[ACC_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                acc_q <= '0;
    else if (flush_i || zero_i) acc_q <= '0;
    else                        acc_q <= sum;
  end

endmodule

// File: rtl/lms_tap_slice.sv
module lms_tap_slice
  import lms_ss_pkg::*;
#(
  parameter tap_kind_e   KIND      = TAP_ADAPT,
  parameter int unsigned COEF_W    = 8,
  parameter int unsigned ACC_W     = 14,
  parameter bit          UP_ON_POS = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cnt_i,
  input  logic                     pos_i,
  input  logic                     flush_i,
  input  logic                     en_i,
  output logic signed [COEF_W-1:0] coef_o
);

  localparam logic signed [COEF_W-1:0] C_MAX   = {1'b0, {(COEF_W-1){1'b1}}};
  localparam logic signed [COEF_W-1:0] C_MIN   = {1'b1, {(COEF_W-1){1'b0}}};
  localparam logic signed [COEF_W-1:0] C_ONE   = {{(COEF_W-1){1'b0}}, 1'b1};
  localparam logic signed [COEF_W-1:0] C_UNITY = C_ONE << (COEF_W-2);

  generate
    if (KIND == TAP_ADAPT) begin : g_adapt
      logic inc, dec, raise, lower;
      logic signed [COEF_W-1:0] coef_q;

      lms_sign_acc #(.ACC_W(ACC_W)) u_acc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cnt_i   (cnt_i),
        .pos_i   (pos_i),
        .flush_i (flush_i),
        .zero_i  (!en_i),
        .inc_o   (inc),
        .dec_o   (dec)
      );

      assign raise = UP_ON_POS ? inc : dec;
      assign lower = UP_ON_POS ? dec : inc;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    coef_q <= '0;
        else if (!en_i) coef_q <= '0;
        else if (flush_i) begin
          if (raise && (coef_q != C_MAX))      coef_q <= coef_q + C_ONE;
          else if (lower && (coef_q != C_MIN)) coef_q <= coef_q - C_ONE;
        end
      end

      assign coef_o = coef_q;
    end else begin : g_pinned
      logic unused_pins;
      assign unused_pins = ^{clk_i, rst_ni, cnt_i, pos_i, flush_i, en_i};
      assign coef_o = (KIND == TAP_UNITY) ? C_UNITY : '0;
    end
  endgenerate

endmodule

// File: rtl/lms_level_pair.sv
module lms_level_pair #(
  parameter int unsigned LVL_W    = 8,
  parameter int unsigned ACC_W    = 14,
  parameter int unsigned IN_INIT  = 16,
  parameter int unsigned OUT_INIT = 48
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cnt_i,
  input  logic                    err_neg_i,
  input  logic [1:0]              sym_i,
  input  logic                    flush_i,
  output logic signed [LVL_W-1:0] in_mag_o,
  output logic signed [LVL_W-1:0] out_mag_o
);

  localparam logic signed [LVL_W:0] L_MAX = {2'b00, {(LVL_W-1){1'b1}}};
  localparam logic signed [LVL_W:0] L_ONE = {{LVL_W{1'b0}}, 1'b1};

  logic outer, pos;
  logic i_inc, i_dec, o_inc, o_dec;
  logic signed [LVL_W-1:0] l1_q, l3_q;
  logic signed [LVL_W:0]   c1, c3, lo3;
  logic unused_msb;

  assign outer = (sym_i[1] == sym_i[0]);
  assign pos   = err_neg_i ^ sym_i[1];

  lms_sign_acc #(.ACC_W(ACC_W)) u_acc_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt_i && !outer),
    .pos_i   (pos),
    .flush_i (flush_i),
    .zero_i  (1'b0),
    .inc_o   (i_inc),
    .dec_o   (i_dec)
  );

  lms_sign_acc #(.ACC_W(ACC_W)) u_acc_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt_i && outer),
    .pos_i   (pos),
    .flush_i (flush_i),
    .zero_i  (1'b0),
    .inc_o   (o_inc),
    .dec_o   (o_dec)
  );

  // outer first, then inner clamped under the new outer: ordering kept
  always_comb begin
    c3 = {l3_q[LVL_W-1], l3_q};
    if (o_inc)      c3 = c3 + L_ONE;
    else if (o_dec) c3 = c3 - L_ONE;
    if (c3 > L_MAX) c3 = L_MAX;
    lo3 = {l1_q[LVL_W-1], l1_q} + L_ONE;
    if (c3 < lo3)   c3 = lo3;

    c1 = {l1_q[LVL_W-1], l1_q};
    if (i_inc)      c1 = c1 + L_ONE;
    else if (i_dec) c1 = c1 - L_ONE;
    if (c1 < L_ONE)      c1 = L_ONE;
    if (c1 > c3 - L_ONE) c1 = c3 - L_ONE;
  end

  assign unused_msb = c1[LVL_W] ^ c3[LVL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l1_q <= LVL_W'(IN_INIT);
      l3_q <= LVL_W'(OUT_INIT);
    end else if (flush_i) begin
      l1_q <= c1[LVL_W-1:0];
      l3_q <= c3[LVL_W-1:0];
    end
  end

  assign in_mag_o  = l1_q;
  assign out_mag_o = l3_q;

endmodule

// File: rtl/lms_ss_adapt.sv
module lms_ss_adapt
  import lms_ss_pkg::*;
#(
  parameter int unsigned NUM_PRE      = 6,
  parameter int unsigned NUM_POST     = 24,
  parameter int unsigned COEF_W       = 8,
  parameter int unsigned LVL_W        = 8,
  parameter int unsigned WIN_LOG2     = 12,
  parameter int unsigned LVL_IN_INIT  = 16,
  parameter int unsigned LVL_OUT_INIT = 48
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic                                        sym_vld_i,
  input  logic                                        err_neg_i,
  input  logic [1:0]                                  sym_i,
  input  logic [NUM_PRE+NUM_POST:0]                   x_neg_i,
  input  logic [NUM_PRE+NUM_POST:0]                   tap_en_i,
  output logic [(NUM_PRE+NUM_POST+1)*COEF_W-1:0]      taps_o,
  output logic [COEF_W-1:0]                           dfe_o,
  output logic [4*LVL_W-1:0]                          lvl_o,
  output logic                                        done_o
);

  localparam int unsigned NUM_TAPS = NUM_PRE + NUM_POST + 1;
  localparam int unsigned MAIN_IDX = NUM_PRE;
  localparam int unsigned ACC_W    = WIN_LOG2 + 2;

  logic [WIN_LOG2-1:0] win_q;
  logic [1:0]          prev_q;
  logic                flush, done_q;

  assign flush = sym_vld_i && (&win_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      prev_q <= 2'd0;
      done_q <= 1'b0;
    end else begin
      done_q <= flush;
      if (sym_vld_i) begin
        win_q  <= win_q + 1'b1;
        prev_q <= sym_i;
      end
    end
  end

  genvar k;
  generate
    for (k = 0; k < NUM_TAPS; k++) begin : g_tap
      logic signed [COEF_W-1:0] coef;
      lms_tap_slice #(
        .KIND      (kind_of(k, MAIN_IDX)),
        .COEF_W    (COEF_W),
        .ACC_W     (ACC_W),
        .UP_ON_POS (1'b0)
      ) u_slice (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cnt_i   (sym_vld_i),
        .pos_i   (err_neg_i ~^ x_neg_i[k]),
        .flush_i (flush),
        .en_i    (tap_en_i[k]),
        .coef_o  (coef)
      );
      assign taps_o[k*COEF_W +: COEF_W] = coef;
    end
  endgenerate

  logic signed [COEF_W-1:0] dfe_coef;

  // DFE: product of error sign and previous decision sign
  lms_tap_slice #(
    .KIND      (TAP_ADAPT),
    .COEF_W    (COEF_W),
    .ACC_W     (ACC_W),
    .UP_ON_POS (1'b1)
  ) u_dfe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (sym_vld_i),
    .pos_i   (err_neg_i ^ prev_q[1]),
    .flush_i (flush),
    .en_i    (1'b1),
    .coef_o  (dfe_coef)
  );

  logic signed [LVL_W-1:0] l_in, l_out;

  lms_level_pair #(
    .LVL_W    (LVL_W),
    .ACC_W    (ACC_W),
    .IN_INIT  (LVL_IN_INIT),
    .OUT_INIT (LVL_OUT_INIT)
  ) u_lvl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (sym_vld_i),
    .err_neg_i (err_neg_i),
    .sym_i     (sym_i),
    .flush_i   (flush),
    .in_mag_o  (l_in),
    .out_mag_o (l_out)
  );

  assign dfe_o  = dfe_coef;
  assign lvl_o  = {l_out, l_in, -l_in, -l_out};
  assign done_o = done_q;

endmodule

// File: rtl/lms_ss_adapt_chk.sv
module lms_ss_adapt_chk #(
  parameter int unsigned NUM_PRE  = 6,
  parameter int unsigned NUM_POST = 24,
  parameter int unsigned COEF_W   = 8,
  parameter int unsigned LVL_W    = 8
) (
  input logic                                   clk_i,
  input logic                                   rst_ni,
  input logic [NUM_PRE+NUM_POST:0]              tap_en_i,
  input logic [(NUM_PRE+NUM_POST+1)*COEF_W-1:0] taps_o,
  input logic [COEF_W-1:0]                      dfe_o,
  input logic [4*LVL_W-1:0]                     lvl_o,
  input logic                                   done_o
);

  localparam int unsigned NUM_TAPS = NUM_PRE + NUM_POST + 1;

  logic signed [LVL_W-1:0] f0, f1, f2, f3;
  assign f0 = lvl_o[0*LVL_W +: LVL_W];
  assign f1 = lvl_o[1*LVL_W +: LVL_W];
  assign f2 = lvl_o[2*LVL_W +: LVL_W];
  assign f3 = lvl_o[3*LVL_W +: LVL_W];

  logic unused_main;
  assign unused_main = tap_en_i[NUM_PRE];

  // R3
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  dfe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(dfe_o));

  // R8
  dfe_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((dfe_o == $past(dfe_o)) || (dfe_o == $past(dfe_o) + 1'b1) ||
                (dfe_o == $past(dfe_o) - 1'b1)));

  // R10
  lvl_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f3 > f2) && (f2 > 0));

  // R10
  lvl_sym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f0 == -f3) && (f1 == -f2));

  genvar k;
  generate
    for (k = 0; k < NUM_TAPS; k++) begin : g_tap
      if (k != NUM_PRE) begin : g_free
        // R6
        mask_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          !$past(tap_en_i[k]) |-> (taps_o[k*COEF_W +: COEF_W] == '0));
        // R2
        tap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (!done_o && $past(tap_en_i[k])) |-> $stable(taps_o[k*COEF_W +: COEF_W]));
      end
    end
  endgenerate

endmodule

bind lms_ss_adapt lms_ss_adapt_chk #(
  .NUM_PRE  (NUM_PRE),
  .NUM_POST (NUM_POST),
  .COEF_W   (COEF_W),
  .LVL_W    (LVL_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tap_en_i (tap_en_i),
  .taps_o   (taps_o),
  .dfe_o    (dfe_o),
  .lvl_o    (lvl_o),
  .done_o   (done_o)
);

// File: tb/lms_ss_adapt_test.sv
`timescale 1ns/1ps
module lms_ss_adapt_test;

  localparam int NP = 6, NQ = 24, NT = NP + NQ + 1;
  localparam int CW = 8, LW = 8, WL = 4, WIN = 1 << WL;
  localparam int L1I = 16, L3I = 48;
  localparam int OW = NT*CW + CW + 4*LW;
  localparam int CMAX = 127, CMIN = -128, LMAX = 127;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sym_vld = 1'b0, err_neg = 1'b0;
  logic [1:0] sym = 2'd0;
  logic [NT-1:0] x_neg = '0, tap_en = '1;
  logic [NT*CW-1:0] taps_o;
  logic [CW-1:0] dfe_o;
  logic [4*LW-1:0] lvl_o;
  logic done_o;

  always #2.5 clk = ~clk;

  lms_ss_adapt #(
    .NUM_PRE(NP), .NUM_POST(NQ), .COEF_W(CW), .LVL_W(LW), .WIN_LOG2(WL),
    .LVL_IN_INIT(L1I), .LVL_OUT_INIT(L3I)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .sym_vld_i(sym_vld), .err_neg_i(err_neg),
    .sym_i(sym), .x_neg_i(x_neg), .tap_en_i(tap_en),
    .taps_o(taps_o), .dfe_o(dfe_o), .lvl_o(lvl_o), .done_o(done_o)
  );

  int n_run = 0, n_fail = 0;
  int exp_tap[NT], acc_t[NT];
  int exp_h = 0, acc_h = 0, l1 = L1I, l3 = L3I, acc_i = 0, acc_o = 0, cnt = 0;
  logic [1:0] prev = 2'd0;
  logic [NT-1:0] en_m = '1;
  string cur_tag = "R2";
  logic [OW-1:0] exp_q[$];
  string tag_q[$];

  function automatic int sgn(input int v);
    return (v > 0) ? 1 : (v < 0) ? -1 : 0;
  endfunction

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic bit free_tap(input int k);
    return (k != NP) && (k != NP + 1);
  endfunction

  function automatic logic [OW-1:0] pack_exp();
    logic [OW-1:0] v;
    v = '0;
    for (int k = 0; k < NT; k++) v[4*LW + CW + k*CW +: CW] = CW'(exp_tap[k]);
    v[4*LW +: CW] = CW'(exp_h);
    v[0 +: LW] = LW'(-l3);
    v[LW +: LW] = LW'(-l1);
    v[2*LW +: LW] = LW'(l1);
    v[3*LW +: LW] = LW'(l3);
    return v;
  endfunction

  function automatic int tap_out(input int k);
    return int'($signed(taps_o[k*CW +: CW]));
  endfunction

  task automatic check_int(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic model_sym(input bit en, input logic [1:0] s, input logic [NT-1:0] x);
    int p, c3, c1;
    for (int k = 0; k < NT; k++)
      if (free_tap(k) && en_m[k]) acc_t[k] += (en == x[k]) ? 1 : -1;
    acc_h += (en != prev[1]) ? 1 : -1;
    p = (en == !s[1]) ? 1 : -1;
    if (s[1] == s[0]) acc_o += p; else acc_i += p;
    prev = s;
    cnt++;
    if (cnt == WIN) begin
      for (int k = 0; k < NT; k++) begin
        if (free_tap(k) && en_m[k]) exp_tap[k] = clampi(exp_tap[k] - sgn(acc_t[k]), CMIN, CMAX);
        acc_t[k] = 0;
      end
      exp_h = clampi(exp_h + sgn(acc_h), CMIN, CMAX);
      c3 = l3 + sgn(acc_o);
      if (c3 > LMAX) c3 = LMAX;
      if (c3 < l1 + 1) c3 = l1 + 1;
      c1 = clampi(l1 + sgn(acc_i), 1, c3 - 1);
      l3 = c3; l1 = c1;
      acc_h = 0; acc_i = 0; acc_o = 0; cnt = 0;
      exp_q.push_back(pack_exp());
      tag_q.push_back(cur_tag);
    end
  endtask

  task automatic drive(input bit v, input bit en, input logic [1:0] s, input logic [NT-1:0] x);
    @(negedge clk);
    sym_vld = v; err_neg = en; sym = s; x_neg = x;
    if (v) model_sym(en, s, x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 2'd0, '0);
  endtask

  task automatic pat(input int mode, input int i, output bit en, output logic [1:0] s,
                     output logic [NT-1:0] x);
    case (mode)
      1:       begin en = i[0]; s = 2'd2; x = '0; end
      2:       begin en = 1'b0; s = i[0] ? 2'd3 : 2'd1; x = i[0] ? '1 : '0; end
      3:       begin en = 1'b1; s = 2'd0; x = '1; end
      4:       begin en = !i[0]; s = i[0] ? 2'd3 : 2'd1; x = i[1] ? '1 : '0; end
      default: begin en = 1'b1; s = 2'd3; x = '0; end
    endcase
  endtask

  task automatic run_win(input int mode, input string tag);
    bit en; logic [1:0] s; logic [NT-1:0] x;
    cur_tag = tag;
    for (int i = 0; i < WIN; i++) begin
      pat(mode, i, en, s, x);
      drive(1'b1, en, s, x);
      if (mode == 5) drive(1'b0, !en, 2'd1, ~x);
    end
    idle(2);
  endtask

  task automatic set_mask(input logic [NT-1:0] m);
    @(negedge clk);
    sym_vld = 1'b0;
    tap_en = m;
    en_m = m;
    for (int k = 0; k < NT; k++)
      if (free_tap(k) && !m[k]) begin exp_tap[k] = 0; acc_t[k] = 0; end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3: unexpected window strobe act=1 exp=0");
      end else begin
        logic [OW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({taps_o, dfe_o, lvl_o} !== e) begin
          n_fail++;
          $display("FAIL %s: window result act=%h exp=%h", t, {taps_o, dfe_o, lvl_o}, e);
        end
      end
    end
  end

  bit finished = 1'b0;

  initial begin
    #(900000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NT; k++) begin
      exp_tap[k] = (k == NP) ? (1 << (CW - 2)) : 0;
      acc_t[k] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_int("R1 taps/dfe/levels", int'({taps_o, dfe_o, lvl_o} === pack_exp()), 1);
    check_int("R1 done", int'(done_o), 0);
    check_int("R1 main", tap_out(NP), 64);

    run_win(0, "R2");
    check_int("R2 tap0 after uniform window", tap_out(0), exp_tap[0]);
    run_win(1, "R4");
    check_int("R4 tap3 unchanged on zero sum", tap_out(3), exp_tap[3]);
    run_win(2, "R9");
    run_win(4, "R9");
    run_win(5, "R3");

    // R3 partial window: no strobe, no change
    cur_tag = "R3";
    for (int i = 0; i < WIN - 1; i++) drive(1'b1, 1'b1, 2'd3, '0);
    idle(3);
    check_int("R3 no strobe before window end", int'(done_o), 0);
    check_int("R3 tap0 held mid window", tap_out(0), exp_tap[0]);
    drive(1'b1, 1'b1, 2'd3, '0);
    idle(2);

    // R5 pinned taps
    check_int("R5 main unity", tap_out(NP), 64);
    check_int("R5 first post zero", tap_out(NP + 1), 0);

    // R6 mask
    set_mask(~((NT'(1) << 0) | (NT'(1) << 20) | (NT'(1) << NP) | (NT'(1) << (NP + 1))));
    @(negedge clk);
    check_int("R6 masked tap0 zero", tap_out(0), 0);
    check_int("R6 masked tap20 zero", tap_out(20), 0);
    check_int("R5 main ignores mask", tap_out(NP), 64);
    run_win(0, "R6");
    check_int("R6 masked tap20 stays zero", tap_out(20), 0);
    set_mask('1);
    run_win(0, "R6");
    check_int("R6 re-enabled tap0 adapts from zero", tap_out(0), 1);

    // R7 positive saturation, R10 outer clamp
    for (int w = 0; w < 135; w++) run_win(0, "R7");
    check_int("R7 tap1 at max", tap_out(1), CMAX);
    check_int("R7 dfe at min", int'($signed(dfe_o)), CMIN);
    check_int("R10 outer held above inner", int'($signed(lvl_o[3*LW +: LW])),
              int'($signed(lvl_o[2*LW +: LW])) + 1);

    // R7 negative saturation
    for (int w = 0; w < 260; w++) run_win(3, "R7");
    check_int("R7 tap1 at min", tap_out(1), CMIN);
    check_int("R8 dfe tracks model", int'($signed(dfe_o)), exp_h);

    // R10 inner clamp under outer
    for (int w = 0; w < 120; w++) run_win(4, "R10");
    check_int("R10 outer at max", int'($signed(lvl_o[3*LW +: LW])), LMAX);
    check_int("R10 inner one below outer", int'($signed(lvl_o[2*LW +: LW])), LMAX - 1);
    check_int("R10 symmetric", int'($signed(lvl_o[0 +: LW])), -LMAX);

    idle(4);
    check_int("R3 all windows observed", exp_q.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule